// File: doc/BRIEF.md
# Per-CPU Bus Interrupt Mailbox

This block holds one mailbox per processor for interrupt messages that arrive from a system bus. A message names a destination processor and carries a 5-bit source ID and two 64-bit data words. If the destination mailbox is free, the block raises `msgAccept` in that same cycle. At the next clock edge it stores the message, marks the mailbox busy and posts an interrupt to that processor. The interrupt carries a vector taken from one 6-bit register that all processors share. If the mailbox is still busy, `msgAccept` stays low and the sender must try again later.

Software sees the mailboxes through a register port. The port has indexed windows, where the mailbox number comes from the address, and alias addresses, where the mailbox is the one that belongs to the requesting processor (`reqCpu`). Software reads the two data words and a status word holding the busy flag and the source ID. It frees a mailbox by writing the busy bit as zero. Reads are combinational from the address in the same cycle, and writes take effect at the clock edge.

Top module: `cpu_irq_mailbox`

## Requirements
- R1: After reset every mailbox is free, with source and data at zero, the shared vector is zero and `irqPost` is low.
- R2: `msgAccept` is high exactly when `msgValid` is high, the destination mailbox is free and no status write to that same mailbox happens in the cycle. On the clock edge of an accepted message, the mailbox becomes busy and stores the source ID and both data words.
- R3: A message to a busy mailbox sees `msgAccept` low and leaves the stored source and data unchanged.
- R4: In the cycle after an acceptance, `irqPost` is high for exactly one cycle. `irqCpu` is the destination and `irqVec` is the shared vector as it stood when the message was accepted. In every other cycle `irqPost` is low.
- R5: A write to the vector register keeps only bits 5:0 of the write data, and a read returns them zero-extended.
- R6: A status read returns the busy flag at bit 5 and the source ID at bits 4:0, with every other bit zero.
- R7: A status write sets the busy flag to data bit 5 and leaves the source ID and the data words as they were. Writing 1 makes the mailbox refuse messages.
- R8: Address layout: bits [10:8] select the region and bits [7:3] are the mailbox index for windows. Bits [2:0] are ignored. The region codes are: 0 data-word-0 window, 1 data-word-1 window, 2 status window, 3 data-word-0 alias, 4 data-word-1 alias, 5 status alias, 6 vector register, 7 reads zero.
- R9: The alias regions ignore the address index and use the mailbox numbered by `reqCpu`.
- R10: If a message arrives in the same cycle as a status write to its mailbox, the message is refused. The same message is accepted in the next cycle if the mailbox is then free.
- R11: Writes to the data-word windows and data-word aliases change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msgValid | input | 1 | A bus message is offered this cycle |
| msgCpu | input | 5 | Destination mailbox of the message |
| msgSrc | input | 5 | Source ID of the message |
| msgData0 | input | 64 | First data word of the message |
| msgData1 | input | 64 | Second data word of the message |
| msgAccept | output | 1 | The message is taken this cycle |
| regEn | input | 1 | Register access this cycle |
| regWrite | input | 1 | 1 for write, 0 for read |
| regAddr | input | 11 | Register byte address |
| reqCpu | input | 5 | Processor making the access, used by alias regions |
| regWdata | input | 64 | Write data |
| regRdata | output | 64 | Read data for the current address |
| irqPost | output | 1 | One-cycle interrupt post |
| irqCpu | output | 5 | Processor receiving the interrupt |
| irqVec | output | 6 | Vector of the posted interrupt |

## Verification
The acceptance path is driven with messages to free mailboxes, to busy mailboxes, to mailboxes that software itself set busy, and to a mailbox in the same cycle as a status write to it. Comparing these cases separates the busy-based refusal from the collision refusal. It also shows that a refused message corrupts no stored word. Messages go to mailbox 0, to mailbox 31 and to two different mailboxes back to back. These cases test index decoding at both ends and the one-cycle interrupt pulse per acceptance. Each mailbox is read through its window and through its alias with a matching and a non-matching `reqCpu`, which shows whether the alias follows the requester rather than the address. The vector register is changed between acceptances so that the posted vector can be checked as the value current when each message was accepted.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int SRC_W    = 5;
  localparam int VEC_W    = 6;
  localparam int BUSY_BIT = 5;
  localparam int REGION_W = 3;
  localparam int WORD_LSB = 3;

  typedef enum logic [REGION_W-1:0] {
    RG_DATA0  = 3'd0,
    RG_DATA1  = 3'd1,
    RG_STAT   = 3'd2,
    RG_ADATA0 = 3'd3,
    RG_ADATA1 = 3'd4,
    RG_ASTAT  = 3'd5,
    RG_VEC    = 3'd6,
    RG_NONE   = 3'd7
  } regionE;

  typedef struct packed {
    logic   acceptEn;
    logic   statusWrEn;
    logic   vecWrEn;
    regionE rdSel;
  } strobeT;

endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int NUM_CPU = 32,
  parameter int CPU_W   = 5,
  parameter int ADDR_W  = 11
) (
  input  logic              msgValid,
  input  logic [CPU_W-1:0]  msgCpu,
  input  logic              regEn,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CPU_W-1:0]  reqCpu,
  input  logic [NUM_CPU-1:0] busyVec,
  output logic [CPU_W-1:0]  accIdx,
  output logic              msgAccept,
  output strobeT            stb
);

  localparam int SPAN = 2 ** CPU_W;

  regionE region;
  logic   isAlias;
  logic   accOk;
  logic   isStatus;
  logic   collide;
  logic [SPAN-1:0] busyPad;
  logic [CPU_W-1:0] winIdx;
  logic unusedAddrBits;

  assign region  = regionE'(regAddr[ADDR_W-1 -: REGION_W]);
  assign winIdx  = regAddr[WORD_LSB +: CPU_W];
  assign unusedAddrBits = ^regAddr[WORD_LSB-1:0];
  assign isAlias = (region == RG_ADATA0) || (region == RG_ADATA1) || (region == RG_ASTAT);
  assign isStatus = (region == RG_STAT) || (region == RG_ASTAT);
  assign accIdx  = isAlias ? reqCpu : winIdx;

  // Slots past NUM_CPU look permanently busy and unaddressable.
  if (SPAN > NUM_CPU) begin : g_pad
    assign busyPad = {{(SPAN-NUM_CPU){1'b1}}, busyVec};
    assign accOk   = accIdx < CPU_W'(NUM_CPU);
  end else begin : g_full
    assign busyPad = busyVec;
    assign accOk   = 1'b1;
  end

  always_comb begin
    stb            = '0;
    stb.rdSel      = RG_NONE;
    stb.statusWrEn = regEn && regWrite && isStatus && accOk;
    stb.vecWrEn    = regEn && regWrite && (region == RG_VEC);
    if (regEn && !regWrite && (accOk || region == RG_VEC)) stb.rdSel = region;
    collide        = stb.statusWrEn && (accIdx == msgCpu);
    msgAccept      = msgValid && !busyPad[msgCpu] && !collide;
    stb.acceptEn   = msgAccept;
  end

endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int NUM_CPU = 32,
  parameter int CPU_W   = 5,
  parameter int DATA_W  = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             stb,
  input  logic [CPU_W-1:0]   msgCpu,
  input  logic [SRC_W-1:0]   msgSrc,
  input  logic [DATA_W-1:0]  msgData0,
  input  logic [DATA_W-1:0]  msgData1,
  input  logic [CPU_W-1:0]   accIdx,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [NUM_CPU-1:0] busyVec,
  output logic [DATA_W-1:0]  regRdata,
  output logic               irqPost,
  output logic [CPU_W-1:0]   irqCpu,
  output logic [VEC_W-1:0]   irqVec
);

  logic              busyQ [NUM_CPU];
  logic [SRC_W-1:0]  srcQ  [NUM_CPU];
  logic [DATA_W-1:0] d0Q   [NUM_CPU];
  logic [DATA_W-1:0] d1Q   [NUM_CPU];
  logic [VEC_W-1:0]  vecQ;
  logic unusedWdata;

  assign unusedWdata = ^regWdata[DATA_W-1:VEC_W];

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        busyQ[g] <= 1'b0;
        srcQ[g]  <= '0;
        d0Q[g]   <= '0;
        d1Q[g]   <= '0;
      end else if (stb.acceptEn && msgCpu == CPU_W'(g)) begin
        busyQ[g] <= 1'b1;
        srcQ[g]  <= msgSrc;
        d0Q[g]   <= msgData0;
        d1Q[g]   <= msgData1;
      end else if (stb.statusWrEn && accIdx == CPU_W'(g)) begin
        busyQ[g] <= regWdata[BUSY_BIT];
      end
    end
    assign busyVec[g] = busyQ[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecQ    <= '0;
      irqPost <= 1'b0;
      irqCpu  <= '0;
      irqVec  <= '0;
    end else begin
      if (stb.vecWrEn) vecQ <= regWdata[VEC_W-1:0];
      irqPost <= stb.acceptEn;
      if (stb.acceptEn) begin
        irqCpu <= msgCpu;
        irqVec <= vecQ;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    case (stb.rdSel)
      RG_DATA0, RG_ADATA0: regRdata = d0Q[accIdx];
      RG_DATA1, RG_ADATA1: regRdata = d1Q[accIdx];
      RG_STAT, RG_ASTAT: begin
        regRdata[BUSY_BIT]  = busyQ[accIdx];
        regRdata[SRC_W-1:0] = srcQ[accIdx];
      end
      RG_VEC:  regRdata[VEC_W-1:0] = vecQ;
      default: regRdata = '0;
    endcase
  end

  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.acceptEn |=> busyQ[$past(msgCpu)]);

  // R3
  accept_only_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.acceptEn |-> !busyQ[msgCpu]);

  // R4
  irq_follows_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.acceptEn |=> (irqPost && irqCpu == $past(msgCpu) && irqVec == $past(vecQ)));

  // R7
  status_keeps_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.statusWrEn && !stb.acceptEn) |=> (srcQ[$past(accIdx)] == $past(srcQ[accIdx])));

  // R7
  status_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.statusWrEn |=> (busyQ[$past(accIdx)] == $past(regWdata[BUSY_BIT])));

  // R10
  collide_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.statusWrEn && accIdx == msgCpu) |-> !stb.acceptEn);

endmodule

// File: rtl/cpu_irq_mailbox.sv
module cpu_irq_mailbox
  import mbox_pkg::*;
#(
  parameter int NUM_CPU = 32,
  parameter int DATA_W  = 64,
  localparam int CPU_W  = $clog2(NUM_CPU),
  localparam int ADDR_W = CPU_W + WORD_LSB + REGION_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msgValid,
  input  logic [CPU_W-1:0]  msgCpu,
  input  logic [SRC_W-1:0]  msgSrc,
  input  logic [DATA_W-1:0] msgData0,
  input  logic [DATA_W-1:0] msgData1,
  output logic              msgAccept,
  input  logic              regEn,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CPU_W-1:0]  reqCpu,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqPost,
  output logic [CPU_W-1:0]  irqCpu,
  output logic [VEC_W-1:0]  irqVec
);

  strobeT             stb;
  logic [CPU_W-1:0]   accIdx;
  logic [NUM_CPU-1:0] busyVec;

  mbox_ctrl #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .ADDR_W(ADDR_W)) uCtrl (
    .msgValid (msgValid),
    .msgCpu   (msgCpu),
    .regEn    (regEn),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .reqCpu   (reqCpu),
    .busyVec  (busyVec),
    .accIdx   (accIdx),
    .msgAccept(msgAccept),
    .stb      (stb)
  );

  mbox_datapath #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .DATA_W(DATA_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .msgCpu  (msgCpu),
    .msgSrc  (msgSrc),
    .msgData0(msgData0),
    .msgData1(msgData1),
    .accIdx  (accIdx),
    .regWdata(regWdata),
    .busyVec (busyVec),
    .regRdata(regRdata),
    .irqPost (irqPost),
    .irqCpu  (irqCpu),
    .irqVec  (irqVec)
  );

endmodule

// File: tb/cpu_irq_mailbox_test.sv
`timescale 1ns/1ps
module cpu_irq_mailbox_test;

  localparam int K_READ = 0;
  localparam int K_ACC  = 1;
  localparam int K_IRQ  = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msgValid = 1'b0;
  logic [4:0]  msgCpu = '0;
  logic [4:0]  msgSrc = '0;
  logic [63:0] msgData0 = '0;
  logic [63:0] msgData1 = '0;
  logic        msgAccept;
  logic        regEn = 1'b0;
  logic        regWrite = 1'b0;
  logic [10:0] regAddr = '0;
  logic [4:0]  reqCpu = '0;
  logic [63:0] regWdata = '0;
  logic [63:0] regRdata;
  logic        irqPost;
  logic [4:0]  irqCpu;
  logic [5:0]  irqVec;

  cpu_irq_mailbox uut (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgCpu(msgCpu), .msgSrc(msgSrc),
    .msgData0(msgData0), .msgData1(msgData1), .msgAccept(msgAccept),
    .regEn(regEn), .regWrite(regWrite), .regAddr(regAddr), .reqCpu(reqCpu),
    .regWdata(regWdata), .regRdata(regRdata), .irqPost(irqPost),
    .irqCpu(irqCpu), .irqVec(irqVec)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int          kindQ[$];
  logic [63:0] expQ[$];
  string       tagQ[$];

  bit          busyM[32];
  logic [4:0]  srcM[32];
  logic [63:0] d0M[32];
  logic [63:0] d1M[32];
  logic [5:0]  vecM;
  bit          pendIrq;
  logic [4:0]  pendCpu;
  logic [5:0]  pendVec;

  function automatic logic [10:0] mkAddr(int region, int idx);
    return {region[2:0], idx[4:0], 3'b101};
  endfunction

  function automatic logic [63:0] statusOf(int c);
    return {58'd0, busyM[c], srcM[c]};
  endfunction

  task automatic expect1(int kind, logic [63:0] e, string tag);
    kindQ.push_back(kind);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    msgValid = 1'b0;
    regEn    = 1'b0;
    regWrite = 1'b0;
    if (pendIrq) begin
      expect1(K_IRQ, {52'd0, 1'b1, pendCpu, pendVec}, "R4");
      pendIrq = 0;
    end else begin
      expect1(K_IRQ, 64'd0, "R4");
    end
  endtask

  task automatic sendMsg(int c, logic [4:0] s, logic [63:0] a, logic [63:0] b,
                         bit collide, string tag);
    bit ok;
    msgValid = 1'b1;
    msgCpu   = c[4:0];
    msgSrc   = s;
    msgData0 = a;
    msgData1 = b;
    ok = !busyM[c] && !collide;
    expect1(K_ACC, {63'd0, ok}, tag);
    if (ok) begin
      busyM[c] = 1;
      srcM[c]  = s;
      d0M[c]   = a;
      d1M[c]   = b;
      pendIrq  = 1;
      pendCpu  = c[4:0];
      pendVec  = vecM;
    end
  endtask

  task automatic regWr(int region, int idx, int rq, logic [63:0] w);
    int tgt;
    regEn    = 1'b1;
    regWrite = 1'b1;
    regAddr  = mkAddr(region, idx);
    reqCpu   = rq[4:0];
    regWdata = w;
    tgt = (region >= 3 && region <= 5) ? rq : idx;
    if (region == 2 || region == 5) busyM[tgt] = w[5];
    if (region == 6) vecM = w[5:0];
  endtask

  task automatic regRd(int region, int idx, int rq, logic [63:0] e, string tag);
    regEn    = 1'b1;
    regWrite = 1'b0;
    regAddr  = mkAddr(region, idx);
    reqCpu   = rq[4:0];
    expect1(K_READ, e, tag);
  endtask

  always @(negedge clk) begin
    while (kindQ.size() > 0) begin
      int          k;
      logic [63:0] e;
      logic [63:0] act;
      string       t;
      k = kindQ.pop_front();
      e = expQ.pop_front();
      t = tagQ.pop_front();
      if (k == K_READ)     act = regRdata;
      else if (k == K_ACC) act = {63'd0, msgAccept};
      else                 act = irqPost ? {52'd0, 1'b1, irqCpu, irqVec} : 64'd0;
      checks++;
      if (act !== e) begin
        fails++;
        $display("FAIL %s kind %0d actual %h expected %h", t, k, act, e);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      busyM[i] = 0; srcM[i] = '0; d0M[i] = '0; d1M[i] = '0;
    end
    vecM = '0;
    pendIrq = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    tick(); regRd(2, 0, 0, 64'd0, "R1");
    tick(); regRd(6, 0, 0, 64'd0, "R1");
    tick(); regRd(0, 17, 0, 64'd0, "R1");

    // R5: vector keeps only low six bits
    tick(); regWr(6, 0, 0, 64'hFFFF_FFFF_FFFF_FFC5);
    tick(); regRd(6, 0, 0, 64'h5, "R5");

    // R2 / R4: accept to a free mailbox
    tick(); sendMsg(3, 5'h11, 64'hDEAD_BEEF_0000_0003, 64'h1234_5678_9ABC_DEF0, 0, "R2");
    // R8 / R6: window reads
    tick(); regRd(0, 3, 0, d0M[3], "R8");
    tick(); regRd(1, 3, 0, d1M[3], "R8");
    tick(); regRd(2, 3, 0, 64'h31, "R6");

    // R3: busy mailbox refuses and keeps contents
    tick(); sendMsg(3, 5'h07, 64'h1, 64'h2, 0, "R3");
    tick(); regRd(0, 3, 0, 64'hDEAD_BEEF_0000_0003, "R3");
    tick(); regRd(2, 3, 0, 64'h31, "R3");

    // R9: aliases follow reqCpu, not the address index
    tick(); regRd(3, 9, 3, d0M[3], "R9");
    tick(); regRd(4, 0, 3, d1M[3], "R9");
    tick(); regRd(5, 3, 3, 64'h31, "R9");
    tick(); regRd(5, 3, 4, 64'd0, "R9");

    // R11: data writes ignored
    tick(); regWr(0, 3, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    tick(); regWr(4, 0, 3, 64'h0BAD_0BAD_0BAD_0BAD);
    tick(); regRd(0, 3, 0, 64'hDEAD_BEEF_0000_0003, "R11");
    tick(); regRd(1, 3, 0, 64'h1234_5678_9ABC_DEF0, "R11");

    // R7: release keeps source
    tick(); regWr(2, 3, 0, 64'hFFFF_FFFF_FFFF_FFDF);
    tick(); regRd(2, 3, 0, 64'h11, "R7");
    tick(); regRd(0, 3, 0, 64'hDEAD_BEEF_0000_0003, "R7");

    // R10: collision with status write refuses, next cycle accepts
    tick(); regWr(5, 0, 3, 64'd0); sendMsg(3, 5'h0A, 64'hAAAA, 64'hBBBB, 1, "R10");
    tick(); sendMsg(3, 5'h0A, 64'hAAAA, 64'hBBBB, 0, "R10");
    tick(); regRd(2, 3, 0, 64'h2A, "R10");

    // R7: software sets busy, then message refused
    tick(); regWr(2, 7, 0, 64'h20);
    tick(); regRd(2, 7, 0, 64'h20, "R7");
    tick(); sendMsg(7, 5'h01, 64'h5, 64'h6, 0, "R3");
    tick(); regWr(5, 0, 7, 64'd0);
    tick(); sendMsg(7, 5'h01, 64'h5, 64'h6, 0, "R2");

    // R8 boundaries and back-to-back acceptances, new vector (R4)
    tick(); regWr(6, 0, 0, 64'h3F);
    tick(); sendMsg(31, 5'h1F, 64'hF0F0, 64'h0F0F, 0, "R2");
    tick(); sendMsg(0, 5'h02, 64'h1111, 64'h2222, 0, "R2");
    tick(); regRd(0, 31, 0, 64'hF0F0, "R8");
    tick(); regRd(2, 31, 0, 64'h3F, "R6");
    tick(); regRd(1, 0, 0, 64'h2222, "R8");
    tick(); regRd(7, 0, 0, 64'd0, "R8");

    tick();
    tick();
    @(negedge clk);
    #1;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule